// File: doc/BRIEF.md
# ADC Input Multiplexer Sequencer

This block shares one delta-sigma converter among the analog inputs of a metering front end. Each frame it walks a short list of slots. For every slot it selects a channel, pulses a conversion start and waits a number of slow-clock ticks that depends on the resolution setting. It then writes the converter result, shifted left, into a RAM word whose address is fixed by the slot and the channel.

A frame starts on an external frame-start pulse. The frame length is 2, 3 or 4 slots. A rising edge on a request bit arms one alternate frame. In that frame the two current slots are replaced by a temperature input and a battery input, and their results go to separate RAM words. At each accepted frame start the block also sets the polarity of the reference chopper: fixed normal, fixed inverted, or flipped once per frame.

The block runs on the system clock. It advances only on a one-cycle `tick` enable that marks each period of the 32768 Hz clock.

Top module: `adc_mux_seq`

## Requirements
- R1: After synchronous reset, `busy`, `conv_start`, `wr_en` and `chop_pol` are all 0.
- R2: A `frame_go` pulse seen while idle raises `busy` on the next clock edge and gives a one-clock `conv_start` for slot 0 on that same edge.
- R3: In a normal frame, `chan_sel` carries, slot by slot from slot 0 upward, the codes 0 (current A), 1 (voltage A), 2 (current B), 3 (voltage B).
- R4: `cfg_len` is sampled at frame start and gives the slot count: 2, 3 or 4. Values below 2 act as 2 and values above 4 act as 4. Exactly that many conversions and writes occur. `busy` falls on the edge that ends the last conversion.
- R5: Each conversion lasts 2 ticks when `cfg_res` is 0 and 3 ticks when it is 1, with `cfg_res` sampled at frame start. The write pulse appears one clock after the edge that takes the final tick, and the next slot's `conv_start` appears on that same edge.
- R6: `wr_addr` is RAM_BASE plus the slot index. In an alternate frame, slots 0 and 2 instead use RAM_BASE + ALT_OFS + slot. `wr_data` is `adc_data`, sampled at the final tick, shifted left by SHIFT bits with zero fill.
- R7: A rising edge on `cfg_alt` arms one alternate frame, which starts at the next accepted frame start. In it, slot 0 carries code 4 (temperature) and slot 2 carries code 5 (battery); slots 1 and 3 are unchanged. A rise during a frame does not alter that frame. Holding `cfg_alt` high gives only one alternate frame.
- R8: At each accepted frame start, `cfg_chop` sets `chop_pol`: 0 gives 0, 1 gives 1, and 2 or 3 invert it. At no other time does `chop_pol` change.
- R9: A `frame_go` pulse while `busy` is high has no effect on the slot sequence, the timing or `chop_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock enable per slow-clock period |
| frame_go | input | 1 | Frame-start pulse |
| cfg_len | input | 3 | Slots per frame (2 to 4) |
| cfg_alt | input | 1 | Alternate-frame request, edge sensitive |
| cfg_res | input | 1 | Resolution select: 0 for 2-tick, 1 for 3-tick conversions |
| cfg_chop | input | 2 | Chopper mode: 0 normal, 1 inverted, 2/3 toggle |
| adc_data | input | DATA_W | Converter result |
| chan_sel | output | 3 | Channel code for the current slot |
| conv_start | output | 1 | One-clock conversion start |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | ADDR_W | RAM write address |
| wr_data | output | DATA_W+SHIFT | Shifted result |
| chop_pol | output | 1 | Reference chopper polarity |
| busy | output | 1 | Frame in progress |

## Verification
The bench sweeps every `cfg_len` value from 0 to 7 against both resolutions and all four chopper modes. This shows the clamping of reserved lengths, the tick count per conversion and the sequence of polarities in toggle mode. Each frame carries a distinct data word, so a write that lands at the wrong slot, address or shift shows up as a data or address mismatch. Alternate-frame cases cover a short pulse before a frame, a pulse inside a running frame, and a level held across two frames. Together they separate edge detection from level detection and show that a request waits for the frame boundary. A second `frame_go` injected mid-frame must leave the tick count and the write list unchanged.

// File: rtl/adc_mux_pkg.sv
package adc_mux_pkg;

  localparam int SLOTS = 4;

  typedef enum logic [2:0] {
    CH_CUR_A = 3'd0,
    CH_VLT_A = 3'd1,
    CH_CUR_B = 3'd2,
    CH_VLT_B = 3'd3,
    CH_TEMP  = 3'd4,
    CH_BATT  = 3'd5
  } chan_e;

  typedef enum logic [1:0] {
    CHOP_NORM = 2'd0,
    CHOP_INV  = 2'd1,
    CHOP_TGL  = 2'd2,
    CHOP_TGL2 = 2'd3
  } chop_e;

  // Channel code for a slot; the alternate frame swaps the two current slots
  function automatic chan_e slot_chan(input logic [1:0] slot, input logic alt);
    chan_e c;
    case (slot)
      2'd0:    c = alt ? CH_TEMP : CH_CUR_A;
      2'd1:    c = CH_VLT_A;
      2'd2:    c = alt ? CH_BATT : CH_CUR_B;
      default: c = CH_VLT_B;
    endcase
    return c;
  endfunction

  // Reserved frame lengths are folded into the legal 2..4 range
  function automatic logic [2:0] clamp_len(input logic [2:0] cfg);
    logic [2:0] l;
    if (cfg < 3'd2)      l = 3'd2;
    else if (cfg > 3'd4) l = 3'd4;
    else                 l = cfg;
    return l;
  endfunction

endpackage

// File: rtl/adc_mux_alt_arm.sv
module adc_mux_alt_arm (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic take,
  output logic pending
);

  logic req_q;
  logic rise;

  assign rise = req & ~req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      req_q   <= req;
      pending <= (pending & ~take) | rise;
    end
  end

  // R7
  alt_arm_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !req_q) |=> pending);

  // R7
  alt_consumed_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !(req && !req_q)) |=> !pending);

endmodule

// File: rtl/adc_mux_chop.sv
module adc_mux_chop
  import adc_mux_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] mode,
  output logic       pol
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pol <= 1'b0;
    end else if (start) begin
      case (chop_e'(mode))
        CHOP_NORM: pol <= 1'b0;
        CHOP_INV:  pol <= 1'b1;
        default:   pol <= ~pol;
      endcase
    end
  end

  // R8
  chop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(pol));

  // R8
  chop_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (start && mode[1]) |=> (pol != $past(pol)));

endmodule

// File: rtl/adc_mux_slot_ctl.sv
module adc_mux_slot_ctl
  import adc_mux_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       go,
  input  logic [2:0] len_cfg,
  input  logic       res_cfg,
  output logic       start,
  output logic       busy,
  output logic [1:0] slot,
  output logic       conv_pulse,
  output logic       conv_end
);

  logic [2:0] len_q;
  logic [1:0] ticks_q;
  logic [1:0] cnt;
  logic       last_slot;

  assign start     = go & ~busy;
  assign conv_end  = busy & tick & (cnt == ticks_q - 2'd1);
  assign last_slot = ({1'b0, slot} == len_q - 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      slot       <= '0;
      cnt        <= '0;
      conv_pulse <= 1'b0;
      len_q      <= 3'd2;
      ticks_q    <= 2'd2;
    end else begin
      conv_pulse <= 1'b0;
      if (start) begin
        busy       <= 1'b1;
        slot       <= '0;
        cnt        <= '0;
        conv_pulse <= 1'b1;
        len_q      <= clamp_len(len_cfg);
        ticks_q    <= res_cfg ? 2'd3 : 2'd2;
      end else if (busy && tick) begin
        if (conv_end) begin
          cnt <= '0;
          if (last_slot) begin
            busy <= 1'b0;
          end else begin
            slot       <= slot + 2'd1;
            conv_pulse <= 1'b1;
          end
        end else begin
          cnt <= cnt + 2'd1;
        end
      end
    end
  end

  // R5
  tick_count_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < ticks_q));

  // R4
  slot_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> ({1'b0, slot} < len_q));

  // R9
  go_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && go && !tick) |=> ($stable(slot) && $stable(cnt) && !conv_pulse));

endmodule

// File: rtl/adc_mux_seq.sv
module adc_mux_seq
  import adc_mux_pkg::*;
#(
  parameter int DATA_W   = 22,
  parameter int SHIFT    = 9,
  parameter int ADDR_W   = 8,
  parameter int RAM_BASE = 16,
  parameter int ALT_OFS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    frame_go,
  input  logic [2:0]              cfg_len,
  input  logic                    cfg_alt,
  input  logic                    cfg_res,
  input  logic [1:0]              cfg_chop,
  input  logic [DATA_W-1:0]       adc_data,
  output logic [2:0]              chan_sel,
  output logic                    conv_start,
  output logic                    wr_en,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [DATA_W+SHIFT-1:0] wr_data,
  output logic                    chop_pol,
  output logic                    busy
);

  localparam int WR_W = DATA_W + SHIFT;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] ALT_A  = ADDR_W'(ALT_OFS);

  logic       start;
  logic [1:0] slot;
  logic       conv_end;
  logic       alt_pend;
  logic       frame_alt;
  logic [ADDR_W-1:0] slot_addr;

  adc_mux_slot_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .go         (frame_go),
    .len_cfg    (cfg_len),
    .res_cfg    (cfg_res),
    .start      (start),
    .busy       (busy),
    .slot       (slot),
    .conv_pulse (conv_start),
    .conv_end   (conv_end)
  );

  adc_mux_alt_arm u_alt (
    .clk     (clk),
    .rst     (rst),
    .req     (cfg_alt),
    .take    (start),
    .pending (alt_pend)
  );

  adc_mux_chop u_chop (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .mode  (cfg_chop),
    .pol   (chop_pol)
  );

  always_ff @(posedge clk) begin
    if (rst) frame_alt <= 1'b0;
    else if (start) frame_alt <= alt_pend;
  end

  assign chan_sel  = slot_chan(slot, frame_alt);
  assign slot_addr = BASE_A + ADDR_W'(slot) + ((frame_alt && !slot[0]) ? ALT_A : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= conv_end;
      if (conv_end) begin
        wr_addr <= slot_addr;
        wr_data <= WR_W'(adc_data) << SHIFT;
      end
    end
  end

  // R2
  start_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

  // R2
  go_idle_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_go && !busy) |=> (busy && conv_start && chan_sel[0] == 1'b0));

  // R6
  write_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr >= BASE_A && wr_addr < BASE_A + ALT_A + ADDR_W'(SLOTS)));

  // R6
  write_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data[SHIFT-1:0] == '0));

endmodule

// File: tb/test_adc_mux_seq.sv
module test_adc_mux_seq;

  localparam int DATA_W = 22;
  localparam int SHIFT  = 9;
  localparam int ADDR_W = 8;
  localparam int BASE   = 16;
  localparam int ALTO   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic frame_go = 1'b0;
  logic [2:0] cfg_len = 3'd4;
  logic cfg_alt = 1'b0;
  logic cfg_res = 1'b0;
  logic [1:0] cfg_chop = 2'd0;
  logic [DATA_W-1:0] adc_data = '0;
  logic [2:0] chan_sel;
  logic conv_start, wr_en, chop_pol, busy;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W+SHIFT-1:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int n_cs, n_wr, n_tk, n_pol_chg;
  int cs_chan [8];
  int wa [8];
  logic [DATA_W+SHIFT-1:0] wd [8];
  bit exp_pol = 0;
  int frame_no = 0;
  logic pol_prev = 1'b0;

  adc_mux_seq #(.DATA_W(DATA_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W),
                .RAM_BASE(BASE), .ALT_OFS(ALTO)) i_adc_mux_seq (
    .clk(clk), .rst(rst), .tick(tick), .frame_go(frame_go), .cfg_len(cfg_len),
    .cfg_alt(cfg_alt), .cfg_res(cfg_res), .cfg_chop(cfg_chop), .adc_data(adc_data),
    .chan_sel(chan_sel), .conv_start(conv_start), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .chop_pol(chop_pol), .busy(busy));

  always #2 clk = ~clk;

  // slow tick: one clock in four
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      tick = (ph == 0);
    end
  end

  // observe outputs between edges
  always @(negedge clk) begin
    if (!rst) begin
      if (conv_start && n_cs < 8) cs_chan[n_cs] = int'(chan_sel);
      if (conv_start) n_cs++;
      if (wr_en && n_wr < 8) begin
        wa[n_wr] = int'(wr_addr);
        wd[n_wr] = wr_data;
      end
      if (wr_en) n_wr++;
      if (tick && busy) n_tk++;
      if (chop_pol !== pol_prev) n_pol_chg++;
      pol_prev = chop_pol;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_alt();
    @(negedge clk); cfg_alt = 1'b1;
    @(negedge clk); cfg_alt = 1'b0;
  endtask

  task automatic do_frame(input int len, input bit res, input int chop,
                          input bit alt_exp, input bit go_mid, input bit alt_mid);
    int el, ct, wait_n;
    logic [DATA_W-1:0] dat;
    el = (len < 2) ? 2 : ((len > 4) ? 4 : len);
    ct = res ? 3 : 2;
    frame_no++;
    dat = DATA_W'(frame_no * 1234567 + len * 40503 + chop * 977 + int'(res) * 3);
    @(negedge clk);
    cfg_len = 3'(len); cfg_res = res; cfg_chop = 2'(chop); adc_data = dat;
    n_cs = 0; n_wr = 0; n_tk = 0; n_pol_chg = 0;
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    #1;
    chk(busy === 1'b1, "R2 busy after go", longint'(busy), 1);
    if (chop == 0) exp_pol = 0;
    else if (chop == 1) exp_pol = 1;
    else exp_pol = ~exp_pol;
    // config changes mid-frame must not matter (sampled at start)
    cfg_len = 3'd7 - 3'(len); cfg_res = ~res; cfg_chop = 2'd2;
    if (go_mid) begin
      repeat (6) @(negedge clk);
      frame_go = 1'b1;
      @(negedge clk);
      frame_go = 1'b0;
    end
    if (alt_mid) pulse_alt();
    wait_n = 0;
    while (busy && wait_n < 400) begin
      @(negedge clk);
      wait_n++;
    end
    repeat (2) @(negedge clk);
    #1;
    chk(n_cs == el, "R4 conversion count", n_cs, el);
    chk(n_wr == el, "R4 write count", n_wr, el);
    chk(n_tk == el * ct, go_mid ? "R9 tick span with stray go" : "R5 tick span",
        n_tk, el * ct);
    chk(chop_pol === exp_pol, "R8 chop polarity", longint'(chop_pol), longint'(exp_pol));
    chk(n_pol_chg <= 1, go_mid ? "R9 chop changes" : "R8 chop changes", n_pol_chg, 1);
    for (int i = 0; i < el && i < 8; i++) begin
      int ec, ea;
      bit sw;
      sw = alt_exp && (i == 0 || i == 2);
      ec = sw ? (i == 0 ? 4 : 5) : i;
      ea = BASE + i + (sw ? ALTO : 0);
      chk(cs_chan[i] == ec, alt_exp ? "R7 alt channel" : "R3 channel order", cs_chan[i], ec);
      chk(wa[i] == ea, "R6 write address", wa[i], ea);
      chk(wd[i] == ({dat, 9'b0}), "R6 write data", longint'(wd[i]), longint'({dat, 9'b0}));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(busy === 1'b0 && conv_start === 1'b0 && wr_en === 1'b0 && chop_pol === 1'b0,
        "R1 reset state", longint'({busy, conv_start, wr_en, chop_pol}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // full sweep of length, resolution and chop mode
    for (int len = 0; len < 8; len++)
      for (int res = 0; res < 2; res++)
        for (int chop = 0; chop < 4; chop++) begin
          bit a;
          a = ((len + res + chop) % 5) == 0;
          if (a) pulse_alt();
          do_frame(len, res[0], chop, a, 1'b0, 1'b0);
        end

    // R9: stray go inside a running frame
    do_frame(4, 1'b1, 2, 1'b0, 1'b1, 1'b0);
    do_frame(3, 1'b0, 0, 1'b0, 1'b1, 1'b0);

    // R7: request raised inside a frame applies to the next one only
    do_frame(4, 1'b0, 1, 1'b0, 1'b0, 1'b1);
    do_frame(4, 1'b0, 1, 1'b1, 1'b0, 1'b0);
    do_frame(4, 1'b0, 1, 1'b0, 1'b0, 1'b0);

    // R7: level held high gives a single alternate frame
    @(negedge clk); cfg_alt = 1'b1;
    do_frame(4, 1'b1, 3, 1'b1, 1'b0, 1'b0);
    do_frame(4, 1'b1, 3, 1'b0, 1'b0, 1'b0);
    @(negedge clk); cfg_alt = 1'b0;
    do_frame(2, 1'b0, 2, 1'b0, 1'b0, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule